// File: doc/BRIEF.md
# Load/Store Address Generation and Data Formatting Unit

This block sits in the memory stage of a load/store datapath. Each request supplies a 64-bit base register value, a signed immediate offset, one of three addressing modes, an access size of one, two, four or eight bytes, and a flag that selects sign or zero extension of loaded data. The block forms the effective address, works out the updated base value and whether it must be written back, derives little-endian byte enables, and steers store data into the right byte lanes of a small synchronous byte-addressed RAM that it models internally.

One cycle after a request, every result is presented at once: the effective address, the byte enables, the base writeback value and its enable, the load result extended to 64 bits, and an alignment flag. The alignment flag is raised when the request marks its base as the stack pointer and that base is not a multiple of 16. The access still goes ahead, because the block has no exception path. The RAM wraps: only the address bits that index its words and lanes are used to reach storage.

Top module: `lsx_ldst`

## Requirements
- R1: In offset mode (req_mode 0), and also for the reserved code 3, the response address is base plus offset, rsp_wb_en is 0 and rsp_wb_base equals the unchanged base.
- R2: In pre-indexed mode (req_mode 1), the response address is base plus offset, rsp_wb_en is 1 and rsp_wb_base equals that same sum.
- R3: In post-indexed mode (req_mode 2), the response address is the unmodified base, rsp_wb_en is 1 and rsp_wb_base is base plus offset.
- R4: The offset is an OFF_W-bit two's complement value, sign-extended to 64 bits before the addition, so negative offsets move the address downward.
- R5: rsp_valid is high exactly in the cycle after a cycle with req_valid high, and the address, byte enables, writeback, alignment flag and load data all belong to that request.
- R6: Size code 0, 1, 2 or 3 selects 1, 2, 4 or 8 bytes. Memory is little-endian: bit i of rsp_be stands for byte lane i, which is address bits [2:0] equal to i. The accessed lanes start at address bits [2:0] rounded down to a multiple of the size.
- R7: A store writes only its enabled lanes. Those lanes take the low-order bytes of req_wdata, and every other byte of memory keeps its value.
- R8: With req_signed 0, a byte, halfword or word load zero-extends bits 8, 16 or 32 and above.
- R9: With req_signed 1, a byte, halfword or word load copies bit 7, 15 or 31 into every higher bit. A doubleword load returns all 64 bits unchanged whatever the flag.
- R10: rsp_align_err is 1 when req_base_is_sp was set and bits [3:0] of the base were not all zero, and 0 in all other cases. The access is still performed.
- R11: During reset and in the first cycle after it, rsp_valid, rsp_wb_en and rsp_align_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 reserved (acts as offset) |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_signed | input | 1 | Sign-extend load data |
| req_base | input | 64 | Base register value |
| req_offset | input | OFF_W | Signed immediate offset |
| req_base_is_sp | input | 1 | Base register is the stack pointer |
| req_wdata | input | 64 | Store data, right-justified |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | 64 | Effective address |
| rsp_be | output | 8 | Byte enables, one per lane |
| rsp_rdata | output | 64 | Extended load result (loads only) |
| rsp_wb_en | output | 1 | Base writeback required |
| rsp_wb_base | output | 64 | New base value |
| rsp_align_err | output | 1 | Stack-pointer base not 16-byte aligned |

## Verification
The checker watches the address and writeback rules of each mode on every cycle, along with the one-cycle response timing, the number of enabled lanes for each size, the upper bits of zero- and sign-extended loads, and the stack-pointer alignment flag. A property cannot show whether a store left its neighbouring bytes alone, or whether a load returns the right bytes from the right lanes. The bench's byte-level memory model covers these through stores of every size that are read back later, loads at every lane with the top bit set and clear, and back-to-back stores and loads to the same address.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

   typedef enum logic [1:0] {
      AM_OFFSET = 2'd0,
      AM_PRE    = 2'd1,
      AM_POST   = 2'd2,
      AM_RSVD   = 2'd3
   } amode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DBL  = 2'd3
   } asize_e;

endpackage

// File: rtl/lsx_agu.sv
module lsx_agu
   import lsx_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int OFF_W = 12
) (
   input  logic [XLEN-1:0]  base_i,
   input  logic [OFF_W-1:0] offset_i,
   input  amode_e           mode_i,
   output logic [XLEN-1:0]  addr_o,
   output logic             wb_en_o,
   output logic [XLEN-1:0]  wb_base_o
);

   localparam int EXT_W = XLEN - OFF_W;

   logic [XLEN-1:0] off_ext;
   logic [XLEN-1:0] sum;

   assign off_ext = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
   assign sum     = base_i + off_ext;

   always_comb begin
      unique case (mode_i)
         AM_PRE: begin
            addr_o    = sum;
            wb_en_o   = 1'b1;
            wb_base_o = sum;
         end
         AM_POST: begin
            addr_o    = base_i;
            wb_en_o   = 1'b1;
            wb_base_o = sum;
         end
         default: begin
            addr_o    = sum;
            wb_en_o   = 1'b0;
            wb_base_o = base_i;
         end
      endcase
   end

endmodule

// File: rtl/lsx_lanes.sv
module lsx_lanes
   import lsx_pkg::*;
#(
   parameter int LANES = 8,
   localparam int LN_W = $clog2(LANES),
   localparam int DW   = LANES * 8
) (
   input  logic [LN_W-1:0] addr_lo_i,
   input  asize_e          size_i,
   input  logic [DW-1:0]   wdata_i,
   output logic [LN_W-1:0] lane_o,
   output logic [LANES-1:0] be_o,
   output logic [DW-1:0]   wdata_o
);

   logic [LN_W:0]   span;
   logic [LN_W-1:0] keep;

   assign span   = (LN_W+1)'((LN_W+1)'(1) << size_i) - (LN_W+1)'(1);
   assign keep   = ~span[LN_W-1:0];
   assign lane_o = addr_lo_i & keep;

   for (genvar g = 0; g < LANES; g++) begin : g_be
      assign be_o[g] = ((LN_W'(g) & keep) == lane_o);
   end

   assign wdata_o = wdata_i << {lane_o, 3'b000};

endmodule

// File: rtl/lsx_ram.sv
module lsx_ram #(
   parameter int WORDS = 32,
   parameter int LANES = 8,
   localparam int IDX_W = $clog2(WORDS),
   localparam int DW    = LANES * 8
) (
   input  logic             clk,
   input  logic             wr_en_i,
   input  logic             rd_en_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [LANES-1:0] be_i,
   input  logic [DW-1:0]    wdata_i,
   output logic [DW-1:0]    rdata_o
);

   for (genvar g = 0; g < LANES; g++) begin : g_bank
      logic [7:0] bank [WORDS];
      logic [7:0] rd_q;

      always_ff @(posedge clk) begin
         if (wr_en_i && be_i[g]) begin
            bank[idx_i] <= wdata_i[g*8 +: 8];
         end
         if (rd_en_i) begin
            rd_q <= bank[idx_i];
         end
      end

      assign rdata_o[g*8 +: 8] = rd_q;
   end

endmodule

// File: rtl/lsx_extend.sv
module lsx_extend
   import lsx_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int LN_W = $clog2(XLEN / 8)
) (
   input  logic [XLEN-1:0] word_i,
   input  logic [LN_W-1:0] lane_i,
   input  asize_e          size_i,
   input  logic            signed_i,
   output logic [XLEN-1:0] data_o
);

   logic [XLEN-1:0] shifted;
   logic            fill;

   assign shifted = word_i >> {lane_i, 3'b000};

   always_comb begin
      fill = 1'b0;
      unique case (size_i)
         SZ_BYTE: begin
            fill   = signed_i & shifted[7];
            data_o = {{(XLEN-8){fill}}, shifted[7:0]};
         end
         SZ_HALF: begin
            fill   = signed_i & shifted[15];
            data_o = {{(XLEN-16){fill}}, shifted[15:0]};
         end
         SZ_WORD: begin
            fill   = signed_i & shifted[31];
            data_o = {{(XLEN-32){fill}}, shifted[31:0]};
         end
         default: begin
            data_o = shifted;
         end
      endcase
   end

endmodule

// File: rtl/lsx_ldst.sv
module lsx_ldst
   import lsx_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int OFF_W     = 12,
   parameter int RAM_WORDS = 32,
   parameter int SP_ALIGN  = 16,
   parameter bit SP_CHECK  = 1'b1,
   localparam int LANES = XLEN / 8,
   localparam int LN_W  = $clog2(LANES),
   localparam int IDX_W = $clog2(RAM_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_store,
   input  logic [1:0]       req_mode,
   input  logic [1:0]       req_size,
   input  logic             req_signed,
   input  logic [XLEN-1:0]  req_base,
   input  logic [OFF_W-1:0] req_offset,
   input  logic             req_base_is_sp,
   input  logic [XLEN-1:0]  req_wdata,
   output logic             rsp_valid,
   output logic [XLEN-1:0]  rsp_addr,
   output logic [LANES-1:0] rsp_be,
   output logic [XLEN-1:0]  rsp_rdata,
   output logic             rsp_wb_en,
   output logic [XLEN-1:0]  rsp_wb_base,
   output logic             rsp_align_err
);

   if (XLEN != 64) begin : g_bad_xlen
      $error("lsx_ldst: XLEN must be 64");
   end
   if (OFF_W < 2 || OFF_W >= XLEN) begin : g_bad_off
      $error("lsx_ldst: OFF_W out of range");
   end
   if (RAM_WORDS < 2 || (RAM_WORDS & (RAM_WORDS - 1)) != 0) begin : g_bad_ram
      $error("lsx_ldst: RAM_WORDS must be a power of two");
   end
   if (SP_ALIGN < 1 || (SP_ALIGN & (SP_ALIGN - 1)) != 0 || SP_ALIGN > 4096) begin : g_bad_align
      $error("lsx_ldst: SP_ALIGN must be a power of two");
   end

   amode_e          mode;
   asize_e          size;
   logic [XLEN-1:0] addr;
   logic            wb_en;
   logic [XLEN-1:0] wb_base;
   logic [LN_W-1:0] lane;
   logic [LANES-1:0] be;
   logic [XLEN-1:0] lane_wdata;
   logic [XLEN-1:0] ram_rdata;
   logic            misalign;

   assign mode = amode_e'(req_mode);
   assign size = asize_e'(req_size);

   lsx_agu #(.XLEN(XLEN), .OFF_W(OFF_W)) u_agu (
      .base_i    (req_base),
      .offset_i  (req_offset),
      .mode_i    (mode),
      .addr_o    (addr),
      .wb_en_o   (wb_en),
      .wb_base_o (wb_base)
   );

   lsx_lanes #(.LANES(LANES)) u_lanes (
      .addr_lo_i (addr[LN_W-1:0]),
      .size_i    (size),
      .wdata_i   (req_wdata),
      .lane_o    (lane),
      .be_o      (be),
      .wdata_o   (lane_wdata)
   );

   lsx_ram #(.WORDS(RAM_WORDS), .LANES(LANES)) u_ram (
      .clk     (clk),
      .wr_en_i (req_valid & req_store),
      .rd_en_i (req_valid & ~req_store),
      .idx_i   (addr[LN_W +: IDX_W]),
      .be_i    (be),
      .wdata_i (lane_wdata),
      .rdata_o (ram_rdata)
   );

   if (SP_CHECK) begin : g_sp_chk
      localparam logic [XLEN-1:0] ALIGN_MASK = XLEN'(SP_ALIGN - 1);
      assign misalign = req_base_is_sp & (|(req_base & ALIGN_MASK));
   end else begin : g_sp_none
      assign misalign = 1'b0;
   end

   logic            q_valid;
   logic [XLEN-1:0] q_addr;
   logic [LANES-1:0] q_be;
   logic            q_wb_en;
   logic [XLEN-1:0] q_wb_base;
   logic            q_align;
   logic [LN_W-1:0] q_lane;
   asize_e          q_size;
   logic            q_signed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid   <= 1'b0;
         q_wb_en   <= 1'b0;
         q_align   <= 1'b0;
         q_addr    <= '0;
         q_be      <= '0;
         q_wb_base <= '0;
         q_lane    <= '0;
         q_size    <= SZ_BYTE;
         q_signed  <= 1'b0;
      end else begin
         q_valid <= req_valid;
         q_wb_en <= req_valid & wb_en;
         q_align <= req_valid & misalign;
         if (req_valid) begin
            q_addr    <= addr;
            q_be      <= be;
            q_wb_base <= wb_base;
            q_lane    <= lane;
            q_size    <= size;
            q_signed  <= req_signed;
         end
      end
   end

   lsx_extend #(.XLEN(XLEN)) u_ext (
      .word_i   (ram_rdata),
      .lane_i   (q_lane),
      .size_i   (q_size),
      .signed_i (q_signed),
      .data_o   (rsp_rdata)
   );

   assign rsp_valid     = q_valid;
   assign rsp_addr      = q_addr;
   assign rsp_be        = q_be;
   assign rsp_wb_en     = q_wb_en;
   assign rsp_wb_base   = q_wb_base;
   assign rsp_align_err = q_align;

endmodule

// File: rtl/lsx_ldst_chk.sv
module lsx_ldst_chk
   import lsx_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int OFF_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_store,
   input logic [1:0]       req_mode,
   input logic [1:0]       req_size,
   input logic             req_signed,
   input logic [XLEN-1:0]  req_base,
   input logic [OFF_W-1:0] req_offset,
   input logic             req_base_is_sp,
   input logic             rsp_valid,
   input logic [XLEN-1:0]  rsp_addr,
   input logic [7:0]       rsp_be,
   input logic [XLEN-1:0]  rsp_rdata,
   input logic             rsp_wb_en,
   input logic [XLEN-1:0]  rsp_wb_base,
   input logic             rsp_align_err
);

   logic [XLEN-1:0] off_sx;
   assign off_sx = {{(XLEN-OFF_W){req_offset[OFF_W-1]}}, req_offset};

   // R1 and R4
   a_r1_offset_keeps_base: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_mode == AM_OFFSET || req_mode == AM_RSVD)) |=>
         (!rsp_wb_en && rsp_wb_base == $past(req_base)
          && rsp_addr == $past(req_base) + $past(off_sx)));

   a_r2_pre_writes_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == AM_PRE) |=>
         (rsp_wb_en && rsp_wb_base == rsp_addr
          && rsp_addr == $past(req_base) + $past(off_sx)));

   a_r3_post_uses_base: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == AM_POST) |=>
         (rsp_wb_en && rsp_addr == $past(req_base)
          && rsp_wb_base == $past(req_base) + $past(off_sx)));

   a_r5_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r5_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_wb_en && !rsp_align_err));

   a_r6_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ($countones(rsp_be) == (1 << $past(req_size))));

   a_r8_unsigned_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store && !req_signed && req_size == SZ_BYTE) |=>
         (rsp_rdata[XLEN-1:8] == '0));

   a_r9_signed_half: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store && req_signed && req_size == SZ_HALF) |=>
         (rsp_rdata[XLEN-1:16] == {(XLEN-16){rsp_rdata[15]}}));

   a_r10_sp_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_base_is_sp && req_base[3:0] != 4'd0) |=> rsp_align_err);

   a_r10_no_false_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (!req_base_is_sp || req_base[3:0] == 4'd0)) |=> !rsp_align_err);

endmodule

bind lsx_ldst lsx_ldst_chk #(.XLEN(XLEN), .OFF_W(OFF_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_store      (req_store),
   .req_mode       (req_mode),
   .req_size       (req_size),
   .req_signed     (req_signed),
   .req_base       (req_base),
   .req_offset     (req_offset),
   .req_base_is_sp (req_base_is_sp),
   .rsp_valid      (rsp_valid),
   .rsp_addr       (rsp_addr),
   .rsp_be         (rsp_be),
   .rsp_rdata      (rsp_rdata),
   .rsp_wb_en      (rsp_wb_en),
   .rsp_wb_base    (rsp_wb_base),
   .rsp_align_err  (rsp_align_err)
);

// File: tb/test_lsx_ldst.sv
module test_lsx_ldst;

   localparam int RAM_WORDS = 32;
   localparam int MEMB      = RAM_WORDS * 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [1:0]  req_mode = '0;
   logic [1:0]  req_size = '0;
   logic        req_signed = 1'b0;
   logic [63:0] req_base = '0;
   logic [11:0] req_offset = '0;
   logic        req_base_is_sp = 1'b0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_addr;
   logic [7:0]  rsp_be;
   logic [63:0] rsp_rdata;
   logic        rsp_wb_en;
   logic [63:0] rsp_wb_base;
   logic        rsp_align_err;

   always #5 clk = ~clk;

   lsx_ldst #(.RAM_WORDS(RAM_WORDS)) i_lsx_ldst (
      .clk, .rst_n, .req_valid, .req_store, .req_mode, .req_size, .req_signed,
      .req_base, .req_offset, .req_base_is_sp, .req_wdata,
      .rsp_valid, .rsp_addr, .rsp_be, .rsp_rdata, .rsp_wb_en, .rsp_wb_base,
      .rsp_align_err
   );

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] ref_mem [MEMB];

   logic        e_valid = 1'b0;
   logic        e_load;
   logic [63:0] e_addr, e_wb_base, e_rdata;
   logic [7:0]  e_be;
   logic        e_wb_en, e_align;
   string       e_mtag, e_dtag;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare();
      chk("R5 rsp_valid", 64'(rsp_valid), 64'(e_valid));
      if (e_valid) begin
         chk({e_mtag, " rsp_addr"}, rsp_addr, e_addr);
         chk({e_mtag, " rsp_wb_en"}, 64'(rsp_wb_en), 64'(e_wb_en));
         chk({e_mtag, " rsp_wb_base"}, rsp_wb_base, e_wb_base);
         chk("R6 rsp_be", 64'(rsp_be), 64'(e_be));
         chk("R10 rsp_align_err", 64'(rsp_align_err), 64'(e_align));
         if (e_load) chk({e_dtag, " rsp_rdata"}, rsp_rdata, e_rdata);
      end else begin
         chk("R5 idle rsp_wb_en", 64'(rsp_wb_en), 64'd0);
         chk("R5 idle rsp_align_err", 64'(rsp_align_err), 64'd0);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      compare();
      req_valid = 1'b0;
      e_valid   = 1'b0;
   endtask

   task automatic issue(bit st, logic [1:0] md, logic [1:0] sz, bit sg,
                        logic [63:0] b, logic [11:0] off, bit sp, logic [63:0] wd);
      logic [63:0] soff, sum, val;
      logic signed [63:0] sval;
      int nb, lane, base_i, sh;
      @(negedge clk);
      compare();
      req_valid = 1'b1; req_store = st; req_mode = md; req_size = sz;
      req_signed = sg; req_base = b; req_offset = off; req_base_is_sp = sp;
      req_wdata = wd;
      soff = {{52{off[11]}}, off};
      sum  = b + soff;
      e_valid   = 1'b1;
      e_load    = !st;
      e_wb_en   = (md == 2'd1) || (md == 2'd2);
      e_addr    = (md == 2'd2) ? b : sum;
      e_wb_base = e_wb_en ? sum : b;
      e_mtag    = (md == 2'd1) ? "R2" : (md == 2'd2) ? "R3" : "R1";
      e_align   = sp && (b[3:0] != 4'd0);
      nb   = 1 << sz;
      lane = (int'(e_addr[2:0]) / nb) * nb;
      e_be = 8'(((1 << nb) - 1) << lane);
      base_i = int'(e_addr[7:3]) * 8 + lane;
      if (st) begin
         for (int k = 0; k < nb; k++) ref_mem[base_i + k] = wd[8*k +: 8];
      end else begin
         val = '0;
         for (int k = 0; k < nb; k++) val = val | (64'(ref_mem[base_i + k]) << (8*k));
         if (sg && nb < 8) begin
            sh   = 64 - 8*nb;
            sval = $signed(val << sh);
            val  = 64'(sval >>> sh);
         end
         e_rdata = val;
         e_dtag  = sg ? "R9" : "R8";
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: nothing is reported straight after reset
      @(negedge clk);
      chk("R11 rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R11 rsp_wb_en", 64'(rsp_wb_en), 64'd0);
      chk("R11 rsp_align_err", 64'(rsp_align_err), 64'd0);

      // fill every RAM word with doubleword stores
      for (int w = 0; w < RAM_WORDS; w++)
         issue(1, 2'd0, 2'd3, 0, 64'(w * 8), 12'd0, 0,
               64'hF1E2_D3C4_B5A6_9788 + 64'(w) * 64'h0123_4567_89AB_CDEF);

      // R8 and R9: every size, both extension modes, every lane
      for (int sz = 0; sz < 4; sz++)
         for (int sg = 0; sg < 2; sg++)
            for (int ln = 0; ln < 8; ln++)
               issue(0, 2'd0, 2'(sz), sg[0], 64'h40 + 64'(ln), 12'd0, 0, '0);

      // R4: negative offsets in all modes, R2/R3 writeback
      issue(0, 2'd1, 2'd3, 0, 64'h100, 12'hFF8, 0, '0);
      issue(1, 2'd2, 2'd2, 0, 64'h88,  12'hFFC, 0, 64'hDEAD_BEEF_8765_4321);
      issue(0, 2'd0, 2'd2, 1, 64'h90,  12'hFF8, 0, '0);
      issue(0, 2'd1, 2'd1, 1, 64'h0,   12'h802, 0, '0);

      // R7: narrow stores, then doubleword readback shows untouched bytes
      issue(1, 2'd0, 2'd0, 0, 64'h23, 12'd0, 0, 64'hFFFF_FFFF_FFFF_FF5A);
      issue(0, 2'd0, 2'd3, 0, 64'h20, 12'd0, 0, '0);
      issue(1, 2'd1, 2'd1, 0, 64'h30, 12'd4, 0, 64'h1111_2222_3333_C3B4);
      idle();
      issue(0, 2'd0, 2'd3, 0, 64'h30, 12'd0, 0, '0);
      issue(1, 2'd0, 2'd2, 0, 64'h38, 12'd4, 0, 64'hAAAA_BBBB_8899_0011);
      issue(0, 2'd0, 2'd3, 1, 64'h38, 12'd0, 0, '0);
      issue(0, 2'd0, 2'd2, 1, 64'h3C, 12'd0, 0, '0);

      // R1: reserved mode behaves as offset mode
      issue(0, 2'd3, 2'd3, 0, 64'h50, 12'd8, 0, '0);

      // R10: stack-pointer alignment
      issue(0, 2'd0, 2'd3, 0, 64'h7FF0, 12'h010, 1, '0);
      issue(0, 2'd0, 2'd3, 0, 64'h7FF8, 12'h008, 1, '0);
      issue(1, 2'd1, 2'd3, 0, 64'h7FF4, 12'hFFC, 1, 64'h0123_4567_89AB_CDEF);
      issue(0, 2'd0, 2'd3, 0, 64'h7FF8, 12'h000, 0, '0);
      idle();
      idle();

      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         logic [63:0] rb;
         rb = {$urandom(), $urandom()};
         if (($urandom() % 5) == 0) idle();
         issue(($urandom() % 3) == 0, 2'($urandom()), 2'($urandom()), 1'($urandom()),
               rb, 12'($urandom()), ($urandom() % 4) == 0,
               {$urandom(), $urandom()});
      end
      idle();
      idle();
      summary();
      $finish;
   end

endmodule